// File: doc/BRIEF.md
# GPIO Interrupt Controller with Per-Pin Sense

The block watches a vector of already-synchronized GPIO levels and turns selected transitions or levels into latched pending events, one bit per pin. Software chooses, for each pin, what counts as an event: a rising edge, a falling edge, either edge, a high level or a low level. The choice is a 4-bit code packed eight to a 32-bit configuration word. A detection-enable word gates whether a pin may capture new events at all. An unmask vector, changed only through separate set and clear write addresses, decides which pending bits reach the single interrupt line.

Software reads either the unmasked pending vector or the masked one. The lowest set bit of the masked vector names the next pin to service. It acknowledges that pin by writing a one to its bit at the clear address. For a level sense the pending bit refills while the level persists, so the acknowledge only holds once the pin has gone inactive. To reconfigure a pin's sense safely, software drops the pin's detection enable, rewrites the field, clears the pin's pending bit and re-enables it.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every readable location returns zero and irq_o is low: detection disabled, all pins masked, all sense fields 0, nothing pending.
- R2: Sense code 8 sets a pin's pending bit at the clock edge where the pin is sampled 1 after being sampled 0 at the previous edge.
- R3: Sense code 9 sets the pending bit on a sampled 1-to-0 transition.
- R4: Sense code 12 sets the pending bit on a sampled transition in either direction.
- R5: Sense code 10 sets the pending bit at every edge where the pin is sampled 1, so a clear written while the pin stays high has no lasting effect.
- R6: Sense code 11 behaves like R5 with the pin sampled 0.
- R7: Any other sense code (0 to 7, 13 to 15) never sets the pending bit.
- R8: Offset 0x14 is a read/write detection enable with bit n for pin n; a pin whose bit is 0 captures no new event, and a bit that is already pending stays pending.
- R9: Writing ones to offset 0x18 unmasks those pins and writing ones to offset 0x1C masks them; zero bits leave the state unchanged; a read of 0x18 returns the unmask vector, with 1 meaning unmasked.
- R10: Writing ones to offset 0x28 clears those pending bits; an event for the same pin at the same edge wins and the bit stays set.
- R11: A read of 0x20 returns the pending vector and a read of 0x24 returns pending AND unmask; irq_o is high exactly when that masked vector is nonzero.
- R12: Pin n's sense field sits in the word at offset 0x40 + 4*(n/8), bits [4*(n%8)+3 : 4*(n%8)], and each such word reads back as written.
- R13: rdata_o presents the value of a read in the cycle after the request, taken from the state before that edge; a read of any other offset, including 0x1C and 0x28, returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one access per cycle |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, registered |
| pin_i | input | NUM_PINS | Synchronized pin levels |
| irq_o | output | 1 | Interrupt request, high while any unmasked pin is pending |

## Verification
A pin sampled at edge k, or a clear or enable write applied at edge k, shows in the pending vector and on irq_o straight after edge k, because irq_o is combinational from the pending and unmask registers. Read data also appears after edge k, but it carries the pre-edge state, so a read issued in the same cycle as an event does not yet show it. The bench drives each access or pin change half a cycle before edge k and advances its reference model by exactly that edge. It then samples irq_o and rdata_o at the following falling edge, so every comparison is made one edge after the stimulus, against the model state of the matching cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int FIELD_W = 4;

  typedef enum logic [FIELD_W-1:0] {
    SNS_RISE = 4'd8,
    SNS_FALL = 4'd9,
    SNS_HIGH = 4'd10,
    SNS_LOW  = 4'd11,
    SNS_BOTH = 4'd12
  } sense_e;

  localparam logic [7:0] OFS_DET_EN = 8'h14;
  localparam logic [7:0] OFS_UNMASK = 8'h18;
  localparam logic [7:0] OFS_MASK   = 8'h1C;
  localparam logic [7:0] OFS_RAW    = 8'h20;
  localparam logic [7:0] OFS_STAT   = 8'h24;
  localparam logic [7:0] OFS_CLR    = 8'h28;
  localparam logic [7:0] OFS_SENSE0 = 8'h40;

  function automatic logic sense_hit(logic [FIELD_W-1:0] code, logic prev, logic cur);
    logic hit;
    case (code)
      SNS_RISE: hit = cur & ~prev;
      SNS_FALL: hit = prev & ~cur;
      SNS_BOTH: hit = prev ^ cur;
      SNS_HIGH: hit = cur;
      SNS_LOW:  hit = ~cur;
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  localparam int PINS_PER_REG = DATA_W / FIELD_W,
  localparam int NUM_SENSE    = (NUM_PINS + PINS_PER_REG - 1) / PINS_PER_REG
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [NUM_PINS-1:0]         det_en_o,
  output logic [NUM_PINS-1:0]         unmask_o,
  output logic [NUM_PINS-1:0]         clr_o,
  output logic [NUM_PINS*FIELD_W-1:0] sense_o,
  output logic [NUM_SENSE*DATA_W-1:0] sense_words_o
);
  logic [NUM_PINS-1:0] en_q, unmask_q;
  logic [NUM_PINS-1:0] wbits;

  assign wbits = wdata_i[NUM_PINS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      unmask_q <= '0;
    end else if (wr_i) begin
      if (addr_i == ADDR_W'(OFS_DET_EN)) en_q <= wbits;
      if (addr_i == ADDR_W'(OFS_UNMASK)) unmask_q <= unmask_q | wbits;
      if (addr_i == ADDR_W'(OFS_MASK))   unmask_q <= unmask_q & ~wbits;
    end
  end

  for (genvar r = 0; r < NUM_SENSE; r++) begin : g_sense
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '0;
      else if (wr_i && addr_i == ADDR_W'(int'(OFS_SENSE0) + 4 * r)) word_q <= wdata_i;
    end
    assign sense_words_o[r*DATA_W +: DATA_W] = word_q;
  end

  assign sense_o  = sense_words_o[NUM_PINS*FIELD_W-1:0];
  assign det_en_o = en_q;
  assign unmask_o = unmask_q;
  assign clr_o    = (wr_i && addr_i == ADDR_W'(OFS_CLR)) ? wbits : '0;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PINS-1:0]         pin_i,
  input  logic [NUM_PINS-1:0]         det_en_i,
  input  logic [NUM_PINS*FIELD_W-1:0] sense_i,
  output logic [NUM_PINS-1:0]         evt_o
);
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pin_i;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign evt_o[i] = det_en_i[i] &
                      sense_hit(sense_i[i*FIELD_W +: FIELD_W], prev_q[i], pin_i[i]);
  end
endmodule

// File: rtl/gpio_irq_pending.sv
module gpio_irq_pending #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] evt_i,
  input  logic [NUM_PINS-1:0] clr_i,
  input  logic [NUM_PINS-1:0] unmask_i,
  output logic [NUM_PINS-1:0] raw_o,
  output logic [NUM_PINS-1:0] stat_o
);
  logic [NUM_PINS-1:0] pend_q;

  // new event overrides a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | evt_i;
  end

  assign raw_o  = pend_q;
  assign stat_o = pend_q & unmask_i;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  localparam int PINS_PER_REG = DATA_W / FIELD_W,
  localparam int NUM_SENSE    = (NUM_PINS + PINS_PER_REG - 1) / PINS_PER_REG
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic                irq_o
);
  logic [NUM_PINS-1:0]         det_en, unmask, clr, evt, raw, stat;
  logic [NUM_PINS*FIELD_W-1:0] sense;
  logic [NUM_SENSE*DATA_W-1:0] sense_words;
  logic [DATA_W-1:0]           rd_val, rdata_q;

  gpio_irq_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i          (req_i & we_i),
    .addr_i, .wdata_i,
    .det_en_o      (det_en),
    .unmask_o      (unmask),
    .clr_o         (clr),
    .sense_o       (sense),
    .sense_words_o (sense_words)
  );

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk_i, .rst_ni, .pin_i,
    .det_en_i (det_en),
    .sense_i  (sense),
    .evt_o    (evt)
  );

  gpio_irq_pending #(.NUM_PINS(NUM_PINS)) u_pending (
    .clk_i, .rst_ni,
    .evt_i    (evt),
    .clr_i    (clr),
    .unmask_i (unmask),
    .raw_o    (raw),
    .stat_o   (stat)
  );

  always_comb begin
    rd_val = '0;
    if (addr_i == ADDR_W'(OFS_DET_EN)) rd_val = DATA_W'(det_en);
    if (addr_i == ADDR_W'(OFS_UNMASK)) rd_val = DATA_W'(unmask);
    if (addr_i == ADDR_W'(OFS_RAW))    rd_val = DATA_W'(raw);
    if (addr_i == ADDR_W'(OFS_STAT))   rd_val = DATA_W'(stat);
    for (int r = 0; r < NUM_SENSE; r++) begin
      if (addr_i == ADDR_W'(int'(OFS_SENSE0) + 4 * r)) rd_val = sense_words[r*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (req_i && !we_i)  rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |stat;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  localparam int PINS_PER_REG = DATA_W / FIELD_W,
  localparam int NUM_SENSE    = (NUM_PINS + PINS_PER_REG - 1) / PINS_PER_REG
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        req_i,
  input logic                        we_i,
  input logic [ADDR_W-1:0]           addr_i,
  input logic [DATA_W-1:0]           wdata_i,
  input logic [NUM_PINS-1:0]         pin_i,
  input logic [DATA_W-1:0]           rdata_o,
  input logic                        irq_o,
  input logic [NUM_PINS-1:0]         det_en,
  input logic [NUM_PINS-1:0]         unmask,
  input logic [NUM_PINS*FIELD_W-1:0] sense,
  input logic [NUM_PINS-1:0]         evt,
  input logic [NUM_PINS-1:0]         raw
);
  logic mapped_rd;
  always_comb begin
    mapped_rd = addr_i == ADDR_W'(OFS_DET_EN) || addr_i == ADDR_W'(OFS_UNMASK) ||
                addr_i == ADDR_W'(OFS_RAW)    || addr_i == ADDR_W'(OFS_STAT);
    for (int r = 0; r < NUM_SENSE; r++)
      if (addr_i == ADDR_W'(int'(OFS_SENSE0) + 4 * r)) mapped_rd = 1'b1;
  end

  p_irq_status_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|(raw & unmask)));

  p_no_capture_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw & ~$past(raw)) & ~$past(det_en)) == '0);

  p_unmapped_zero_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_i && !we_i && !mapped_rd) |-> rdata_o == '0);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    p_level_high_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(det_en[i] && pin_i[i] && sense[i*FIELD_W +: FIELD_W] == SNS_HIGH) |-> raw[i]);

    p_clear_takes_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(req_i && we_i && addr_i == ADDR_W'(OFS_CLR) && wdata_i[i] && !evt[i]) |-> !raw[i]);
  end
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
  .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .pin_i(pin_i), .rdata_o(rdata_o), .irq_o(irq_o),
  .det_en(det_en), .unmask(unmask), .sense(sense), .evt(evt), .raw(raw)
);

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, pin_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_irq_ctrl u_gpio_irq_ctrl (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .pin_i, .irq_o
  );

  // reference model
  logic [31:0] m_en = '0, m_unmask = '0, m_pend = '0, m_prev = '0, cur_pins = '0;
  logic [31:0] m_sense [4] = '{default: '0};

  function automatic logic f_hit(logic [3:0] c, logic p, logic n);
    case (c)
      4'd8:    return n & ~p;
      4'd9:    return p & ~n;
      4'd12:   return p ^ n;
      4'd10:   return n;
      4'd11:   return ~n;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] f_read(logic [7:0] a);
    case (a)
      8'h14: return m_en;
      8'h18: return m_unmask;
      8'h20: return m_pend;
      8'h24: return m_pend & m_unmask;
      8'h40: return m_sense[0];
      8'h44: return m_sense[1];
      8'h48: return m_sense[2];
      8'h4C: return m_sense[3];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit rq, bit w, logic [7:0] a, logic [31:0] d, string tag);
    logic [31:0] exp_rd, evt, clr;
    pin_i = cur_pins; req_i = rq; we_i = w; addr_i = a; wdata_i = d;
    exp_rd = f_read(a);
    for (int i = 0; i < 32; i++)
      evt[i] = m_en[i] & f_hit(m_sense[i/8][4*(i%8) +: 4], m_prev[i], cur_pins[i]);
    clr = (rq && w && a == 8'h28) ? d : 32'h0;
    m_pend = (m_pend & ~clr) | evt;
    if (rq && w) begin
      if (a == 8'h14) m_en = d;
      if (a == 8'h18) m_unmask = m_unmask | d;
      if (a == 8'h1C) m_unmask = m_unmask & ~d;
      if (a >= 8'h40 && a <= 8'h4C && a[1:0] == 2'b00) m_sense[(a - 8'h40) >> 2] = d;
    end
    m_prev = cur_pins;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    chk({tag, " irq"}, {31'h0, irq_o}, {31'h0, |(m_pend & m_unmask)});
    if (rq && !w) chk({tag, " rdata"}, rdata_o, exp_rd);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, string tag); cyc(1, 1, a, d, tag); endtask
  task automatic rd(logic [7:0] a, string tag); cyc(1, 0, a, 32'h0, tag); endtask
  task automatic pins(logic [31:0] p, string tag); cur_pins = p; cyc(0, 0, 8'h0, 32'h0, tag); endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset state
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    foreach (m_sense[k]) begin rd(8'h40 + 8'(4*k), "R1"); chk("R1", rdata_o, 32'h0); end
    rd(8'h14, "R1"); chk("R1", rdata_o, 32'h0);
    rd(8'h18, "R1"); chk("R1", rdata_o, 32'h0);
    rd(8'h20, "R1"); chk("R1", rdata_o, 32'h0);
    // R12: pin 11 field at word 1, bits 15:12
    wr(8'h44, 32'h0000_A000, "R12");
    rd(8'h44, "R12"); chk("R12", rdata_o, 32'h0000_A000);
    rd(8'h40, "R12"); chk("R12", rdata_o, 32'h0);
    // pins 0..5: rise, fall, both, high, low, code 3
    wr(8'h40, 32'h003B_AC98, "R12");
    wr(8'h14, 32'hFFFF_FFFF, "R8");
    wr(8'h18, 32'hFFFF_FFFF, "R9");
    rd(8'h18, "R9"); chk("R9", rdata_o, 32'hFFFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF, "R10");
    // R2 / R7
    pins(32'h1, "R2");
    rd(8'h20, "R2"); chk("R2", rdata_o & 32'h1, 32'h1);
    pins(32'h21, "R7"); pins(32'h01, "R7");
    rd(8'h20, "R7"); chk("R7", rdata_o & 32'h20, 32'h0);
    // R3
    pins(32'h3, "R3"); wr(8'h28, 32'h2, "R3");
    pins(32'h1, "R3"); rd(8'h20, "R3"); chk("R3", rdata_o & 32'h2, 32'h2);
    // R4 both directions
    wr(8'h28, 32'h4, "R4"); pins(32'h5, "R4");
    rd(8'h20, "R4"); chk("R4", rdata_o & 32'h4, 32'h4);
    wr(8'h28, 32'h4, "R4"); pins(32'h1, "R4");
    rd(8'h20, "R4"); chk("R4", rdata_o & 32'h4, 32'h4);
    // R5 high level persists through a clear
    pins(32'h9, "R5"); wr(8'h28, 32'h8, "R5");
    rd(8'h20, "R5"); chk("R5", rdata_o & 32'h8, 32'h8);
    pins(32'h1, "R5"); wr(8'h28, 32'h8, "R5");
    rd(8'h20, "R5"); chk("R5", rdata_o & 32'h8, 32'h0);
    // R6 low level on pin 4
    wr(8'h28, 32'h10, "R6");
    rd(8'h20, "R6"); chk("R6", rdata_o & 32'h10, 32'h10);
    pins(32'h11, "R6"); wr(8'h28, 32'h10, "R6");
    rd(8'h20, "R6"); chk("R6", rdata_o & 32'h10, 32'h0);
    // R10 clear and rising edge at the same edge
    pins(32'h10, "R10"); wr(8'h28, 32'h1, "R10");
    cur_pins = 32'h11; cyc(1, 1, 8'h28, 32'h1, "R10");
    rd(8'h20, "R10"); chk("R10", rdata_o & 32'h1, 32'h1);
    // R8 disabled pin keeps old pending, captures nothing new
    wr(8'h14, 32'hFFFF_FFFE, "R8");
    rd(8'h20, "R8"); chk("R8", rdata_o & 32'h1, 32'h1);
    wr(8'h28, 32'h1, "R8"); pins(32'h10, "R8"); pins(32'h11, "R8");
    rd(8'h20, "R8"); chk("R8", rdata_o & 32'h1, 32'h0);
    // R9 / R11 masking
    pins(32'h19, "R9");
    wr(8'h1C, 32'hFFFF_FFFF, "R9");
    chk("R11", {31'h0, irq_o}, 32'h0);
    rd(8'h24, "R11"); chk("R11", rdata_o, 32'h0);
    rd(8'h20, "R11"); chk("R11", rdata_o & 32'h8, 32'h8);
    wr(8'h18, 32'h8, "R9");
    chk("R11", {31'h0, irq_o}, 32'h1);
    rd(8'h24, "R11"); chk("R11", rdata_o, 32'h8);
    // R13 unmapped and write-only offsets
    rd(8'h30, "R13"); chk("R13", rdata_o, 32'h0);
    rd(8'h1C, "R13"); chk("R13", rdata_o, 32'h0);
    rd(8'h28, "R13"); chk("R13", rdata_o, 32'h0);

    // constrained random phase
    void'($urandom(32'd4021));
    for (int k = 0; k < 4; k++) begin
      logic [31:0] s;
      for (int j = 0; j < 8; j++) s[4*j +: 4] = 4'(8 + $urandom % 6);
      wr(8'h40 + 8'(4*k), s, "R12");
    end
    wr(8'h14, $urandom, "R8");
    for (int n = 0; n < 3000; n++) begin
      cur_pins = cur_pins ^ ($urandom & $urandom & $urandom);
      case ($urandom % 9)
        0: pins(cur_pins, "R11");
        1: rd(8'h20, "R11");
        2: rd(8'h24, "R11");
        3: wr(8'h28, $urandom, "R10");
        4: wr(8'h18, $urandom & $urandom, "R9");
        5: wr(8'h1C, $urandom & $urandom, "R9");
        6: if ($urandom % 8 == 0) wr(8'h14, $urandom | $urandom, "R8"); else rd(8'h14, "R8");
        7: if ($urandom % 16 == 0) begin
             logic [31:0] s;
             for (int j = 0; j < 8; j++) s[4*j +: 4] = 4'($urandom % 16);
             wr(8'h40 + 8'(4*($urandom % 4)), s, "R7");
           end else rd(8'h40 + 8'(4*($urandom % 4)), "R12");
        default: rd(8'(4 * ($urandom % 24)), "R13");
      endcase
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule